// File: doc/BRIEF.md
# Store-Pair Micro-Op Expander

This block sits in a decode pipeline. It takes one decoded instruction that stores two registers to memory and turns it into three micro-ops, issued one per cycle. The instruction arrives with its PC, two data register numbers, a base register number, a signed byte offset and a flag that selects 32-bit or 64-bit operands. All three micro-ops carry the parent PC and an index, so later stages can tell them apart and retire them as one unit.

Micro-op 0 is an integer add. It places base plus offset into a private temporary register. Micro-ops 1 and 2 are single-register stores. Both read their address from that temporary register: the first store uses no extra offset, and the second adds the operand size. Flags mark the first and last micro-op, mark every micro-op as a micro-op, and hold back commit until the last micro-op. A valid/ready pair accepts the instruction. A second valid/ready pair hands out the micro-ops, and backpressure freezes the current one.

Register operands on the micro-op side are REG_W+1 bits wide. The top bit is 0 for an architectural register and 1 for a micro-register. The temporary register is micro-register TMP_REG. An unused register field reads 0.

Top module: `stpair_uop_expander`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0 and in_ready is 1.
- R2: Each accepted instruction produces exactly three micro-ops with uop_idx 0, 1 and 2, in that order. The first is valid in the cycle after acceptance, and all of them carry the accepted PC.
- R3: Micro-op 0 has uop_op 2'b01 (add), uop_dst {1,TMP_REG}, uop_srca {0,base}, uop_srcb 0, uop_imm equal to the input offset and uop_bytes 0.
- R4: Micro-op 1 has uop_op 2'b10 (store), uop_dst 0, uop_srca {1,TMP_REG}, uop_srcb {0,first data register} and uop_imm 0.
- R5: Micro-op 2 is a store with uop_srca {1,TMP_REG} and uop_srcb {0,second data register}. Its uop_imm is 8 for 64-bit operands and 4 for 32-bit operands. Both stores report uop_bytes 8 (64-bit) or 4 (32-bit).
- R6: uop_first is 1 only on micro-op 0, uop_last is 1 only on micro-op 2, and uop_micro is 1 on all three.
- R7: uop_delayed is 1 on micro-ops 0 and 1 and 0 on micro-op 2.
- R8: uop_mem and uop_store are 1 on micro-ops 1 and 2 and 0 on micro-op 0. uop_int is 1 on micro-op 0 only.
- R9: in_ready is 0 from the cycle after acceptance until micro-op 2 has been taken with out_ready. It is 1 again, with out_valid 0, in the following cycle.
- R10: While out_valid is 1 and out_ready is 0, every micro-op output keeps its value into the next cycle.
- R11: A zero offset still yields the add micro-op with uop_imm 0, so the sequence still has three micro-ops.
- R12: Input valid and fields presented while in_ready is 0 have no effect on the micro-ops being issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle and able to take an instruction |
| in_pc | input | PC_W | Instruction PC |
| in_rt1 | input | REG_W | First data register |
| in_rt2 | input | REG_W | Second data register |
| in_rn | input | REG_W | Base register |
| in_imm | input | IMM_W | Signed byte offset |
| in_is64 | input | 1 | 1 = 64-bit operands, 0 = 32-bit |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Downstream takes the micro-op |
| uop_pc | output | PC_W | Parent PC |
| uop_idx | output | 2 | Micro-op index |
| uop_op | output | 2 | 01 add, 10 store |
| uop_dst | output | REG_W+1 | Destination register |
| uop_srca | output | REG_W+1 | Add source / store address register |
| uop_srcb | output | REG_W+1 | Store data register |
| uop_imm | output | IMM_W | Add offset / store displacement |
| uop_bytes | output | 4 | Store width in bytes (0 for add) |
| uop_first | output | 1 | First micro-op |
| uop_last | output | 1 | Last micro-op |
| uop_delayed | output | 1 | Commit deferred |
| uop_mem | output | 1 | Memory reference |
| uop_store | output | 1 | Store |
| uop_int | output | 1 | Integer-only operation |
| uop_micro | output | 1 | Is a micro-op |

## Verification
The bench instantiates the block with a 48-bit PC, 5-bit register numbers, a 9-bit offset and a temporary micro-register of 3. With a 9-bit offset, both signed extremes (-256 and 255) can be reached. A nonzero temporary index shows whether the destination encoding on the add and the address operand on the stores actually carry the parameter. Random backpressure between 0 and 2 cycles per micro-op exercises the hold rule on each index. The bench also drives changing input fields while the block is busy, to show that they are ignored.

// File: rtl/stpair_pkg.sv
// Shared definitions for the store-pair expander.
// Assumes a fixed expansion of three micro-ops per instruction.
package stpair_pkg;
    typedef enum logic [1:0] {
        UOP_NONE  = 2'b00,
        UOP_ADD   = 2'b01,
        UOP_STORE = 2'b10
    } uop_op_e;

    localparam int unsigned UOP_COUNT = 3;
    localparam int unsigned IDX_W     = 2;
endpackage

// File: rtl/stpair_hold.sv
// Holds one accepted store-pair instruction and steps a micro-op index
// through the expansion. Assumes the consumer takes a micro-op whenever
// busy and out_ready are both 1. A new instruction is taken only when idle.
module stpair_hold
    import stpair_pkg::*;
#(
    parameter int unsigned PC_W  = 64,
    parameter int unsigned REG_W = 5,
    parameter int unsigned IMM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PC_W-1:0]  in_pc,
    input  logic [REG_W-1:0] in_rt1,
    input  logic [REG_W-1:0] in_rt2,
    input  logic [REG_W-1:0] in_rn,
    input  logic [IMM_W-1:0] in_imm,
    input  logic             in_is64,
    input  logic             out_ready,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic [PC_W-1:0]  pc_q,
    output logic [REG_W-1:0] rt1_q,
    output logic [REG_W-1:0] rt2_q,
    output logic [REG_W-1:0] rn_q,
    output logic [IMM_W-1:0] imm_q,
    output logic             is64_q
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(UOP_COUNT - 1);

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic             take;
    logic             fire;
    logic             fire_last;

    // Handshake events on both sides.
    always_comb begin
        take      = in_valid && !busy_q;
        fire      = busy_q && out_ready;
        fire_last = fire && (idx_q == LAST_IDX);
    end

    // Busy flag and micro-op index sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (take) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (fire_last) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (fire) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    // Capture instruction fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            rt1_q  <= '0;
            rt2_q  <= '0;
            rn_q   <= '0;
            imm_q  <= '0;
            is64_q <= 1'b0;
        end else if (take) begin
            pc_q   <= in_pc;
            rt1_q  <= in_rt1;
            rt2_q  <= in_rt2;
            rn_q   <= in_rn;
            imm_q  <= in_imm;
            is64_q <= in_is64;
        end
    end

    assign busy = busy_q;
    assign idx  = idx_q;

    // R2: an accepted instruction starts at index 0 in the next cycle.
    a_r2_start_idx0: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (busy_q && idx_q == '0));

    // R2: the index never passes the last micro-op.
    a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (idx_q <= LAST_IDX));

    // R9: taking the last micro-op frees the block.
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        fire_last |=> !busy_q);

    // R12: held fields do not move while busy.
    a_r12_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !fire_last) |=> ($stable(pc_q) && $stable(imm_q) && $stable(rt1_q)));
endmodule

// File: rtl/stpair_uop_build.sv
// Forms the micro-op fields for the current index from the held
// instruction. Purely combinational. Assumes idx is 0..2 and that
// IMM_W is at least 5, so the displacement of 8 fits.
module stpair_uop_build
    import stpair_pkg::*;
#(
    parameter int unsigned PC_W    = 64,
    parameter int unsigned REG_W   = 5,
    parameter int unsigned IMM_W   = 12,
    parameter int unsigned TMP_REG = 0
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [PC_W-1:0]  pc_q,
    input  logic [REG_W-1:0] rt1_q,
    input  logic [REG_W-1:0] rt2_q,
    input  logic [REG_W-1:0] rn_q,
    input  logic [IMM_W-1:0] imm_q,
    input  logic             is64_q,
    output logic [PC_W-1:0]  uop_pc,
    output logic [1:0]       uop_op,
    output logic [REG_W:0]   uop_dst,
    output logic [REG_W:0]   uop_srca,
    output logic [REG_W:0]   uop_srcb,
    output logic [IMM_W-1:0] uop_imm,
    output logic [3:0]       uop_bytes,
    output logic             uop_first,
    output logic             uop_last,
    output logic             uop_delayed,
    output logic             uop_mem,
    output logic             uop_store,
    output logic             uop_int,
    output logic             uop_micro
);
    localparam logic [REG_W:0]   TMP_OPND = {1'b1, REG_W'(TMP_REG)};
    localparam logic [IMM_W-1:0] DISP_64  = IMM_W'(8);
    localparam logic [IMM_W-1:0] DISP_32  = IMM_W'(4);

    uop_op_e    op;
    logic [3:0] st_bytes;

    // Per-index field selection.
    always_comb begin
        st_bytes    = is64_q ? 4'd8 : 4'd4;
        op          = UOP_NONE;
        uop_dst     = '0;
        uop_srca    = '0;
        uop_srcb    = '0;
        uop_imm     = '0;
        uop_bytes   = 4'd0;
        uop_first   = 1'b0;
        uop_last    = 1'b0;
        uop_delayed = 1'b0;
        uop_mem     = 1'b0;
        uop_store   = 1'b0;
        uop_int     = 1'b0;
        case (idx)
            2'd0: begin
                op          = UOP_ADD;
                uop_dst     = TMP_OPND;
                uop_srca    = {1'b0, rn_q};
                uop_imm     = imm_q;
                uop_first   = 1'b1;
                uop_delayed = 1'b1;
                uop_int     = 1'b1;
            end
            2'd1: begin
                op          = UOP_STORE;
                uop_srca    = TMP_OPND;
                uop_srcb    = {1'b0, rt1_q};
                uop_bytes   = st_bytes;
                uop_delayed = 1'b1;
                uop_mem     = 1'b1;
                uop_store   = 1'b1;
            end
            default: begin
                op          = UOP_STORE;
                uop_srca    = TMP_OPND;
                uop_srcb    = {1'b0, rt2_q};
                uop_imm     = is64_q ? DISP_64 : DISP_32;
                uop_bytes   = st_bytes;
                uop_last    = 1'b1;
                uop_mem     = 1'b1;
                uop_store   = 1'b1;
            end
        endcase
    end

    assign uop_op    = op;
    assign uop_pc    = pc_q;
    assign uop_micro = 1'b1;
endmodule

// File: rtl/stpair_uop_expander.sv
// Store-pair micro-op expander top. It splits one accepted store-pair
// instruction into an address add and two single-register stores, which
// are issued in order under the parent PC. It assumes the consumer may stall
// at any micro-op and that no new instruction is needed until the last one
// has gone.
module stpair_uop_expander
    import stpair_pkg::*;
#(
    parameter int unsigned PC_W    = 64,
    parameter int unsigned REG_W   = 5,
    parameter int unsigned IMM_W   = 12,
    parameter int unsigned TMP_REG = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PC_W-1:0]  in_pc,
    input  logic [REG_W-1:0] in_rt1,
    input  logic [REG_W-1:0] in_rt2,
    input  logic [REG_W-1:0] in_rn,
    input  logic [IMM_W-1:0] in_imm,
    input  logic             in_is64,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PC_W-1:0]  uop_pc,
    output logic [1:0]       uop_idx,
    output logic [1:0]       uop_op,
    output logic [REG_W:0]   uop_dst,
    output logic [REG_W:0]   uop_srca,
    output logic [REG_W:0]   uop_srcb,
    output logic [IMM_W-1:0] uop_imm,
    output logic [3:0]       uop_bytes,
    output logic             uop_first,
    output logic             uop_last,
    output logic             uop_delayed,
    output logic             uop_mem,
    output logic             uop_store,
    output logic             uop_int,
    output logic             uop_micro
);
    logic             busy;
    logic [IDX_W-1:0] idx;
    logic [PC_W-1:0]  pc_q;
    logic [REG_W-1:0] rt1_q;
    logic [REG_W-1:0] rt2_q;
    logic [REG_W-1:0] rn_q;
    logic [IMM_W-1:0] imm_q;
    logic             is64_q;

    stpair_hold #(
        .PC_W (PC_W),
        .REG_W(REG_W),
        .IMM_W(IMM_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_pc    (in_pc),
        .in_rt1   (in_rt1),
        .in_rt2   (in_rt2),
        .in_rn    (in_rn),
        .in_imm   (in_imm),
        .in_is64  (in_is64),
        .out_ready(out_ready),
        .busy     (busy),
        .idx      (idx),
        .pc_q     (pc_q),
        .rt1_q    (rt1_q),
        .rt2_q    (rt2_q),
        .rn_q     (rn_q),
        .imm_q    (imm_q),
        .is64_q   (is64_q)
    );

    stpair_uop_build #(
        .PC_W   (PC_W),
        .REG_W  (REG_W),
        .IMM_W  (IMM_W),
        .TMP_REG(TMP_REG)
    ) u_build (
        .idx        (idx),
        .pc_q       (pc_q),
        .rt1_q      (rt1_q),
        .rt2_q      (rt2_q),
        .rn_q       (rn_q),
        .imm_q      (imm_q),
        .is64_q     (is64_q),
        .uop_pc     (uop_pc),
        .uop_op     (uop_op),
        .uop_dst    (uop_dst),
        .uop_srca   (uop_srca),
        .uop_srcb   (uop_srcb),
        .uop_imm    (uop_imm),
        .uop_bytes  (uop_bytes),
        .uop_first  (uop_first),
        .uop_last   (uop_last),
        .uop_delayed(uop_delayed),
        .uop_mem    (uop_mem),
        .uop_store  (uop_store),
        .uop_int    (uop_int),
        .uop_micro  (uop_micro)
    );

    assign in_ready  = !busy;
    assign out_valid = busy;
    assign uop_idx   = idx;

    // R10: a stalled micro-op holds every field.
    a_r10_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(uop_idx) && $stable(uop_pc)
            && $stable(uop_op) && $stable(uop_srca) && $stable(uop_srcb)
            && $stable(uop_imm) && $stable(uop_last)));

    // R6: the last flag appears only on index 2.
    a_r6_last_idx2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && uop_last) |-> (uop_idx == 2'd2));

    // R7: delayed commit on every micro-op except the last.
    a_r7_delayed: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (uop_delayed != uop_last));

    // R8: stores are memory references and not integer-only.
    a_r8_store_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && uop_store) |-> (uop_mem && !uop_int));

    // R9: the micro-op after index 0 keeps the same PC until release.
    a_r9_index_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !uop_last) |=> (out_valid && $stable(uop_pc)));
endmodule

// File: tb/stpair_uop_expander_tb.sv
module stpair_uop_expander_tb;
    localparam int unsigned PC_W    = 48;
    localparam int unsigned REG_W   = 5;
    localparam int unsigned IMM_W   = 9;
    localparam int unsigned TMP_REG = 3;
    localparam int unsigned SNAP_W  = PC_W + 2 + 2 + 3 * (REG_W + 1) + IMM_W + 4 + 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [PC_W-1:0]  in_pc = '0;
    logic [REG_W-1:0] in_rt1 = '0;
    logic [REG_W-1:0] in_rt2 = '0;
    logic [REG_W-1:0] in_rn = '0;
    logic [IMM_W-1:0] in_imm = '0;
    logic             in_is64 = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [PC_W-1:0]  uop_pc;
    logic [1:0]       uop_idx;
    logic [1:0]       uop_op;
    logic [REG_W:0]   uop_dst;
    logic [REG_W:0]   uop_srca;
    logic [REG_W:0]   uop_srcb;
    logic [IMM_W-1:0] uop_imm;
    logic [3:0]       uop_bytes;
    logic             uop_first, uop_last, uop_delayed, uop_mem, uop_store, uop_int, uop_micro;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    stpair_uop_expander #(
        .PC_W(PC_W), .REG_W(REG_W), .IMM_W(IMM_W), .TMP_REG(TMP_REG)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pc(in_pc), .in_rt1(in_rt1), .in_rt2(in_rt2), .in_rn(in_rn),
        .in_imm(in_imm), .in_is64(in_is64), .out_valid(out_valid), .out_ready(out_ready),
        .uop_pc(uop_pc), .uop_idx(uop_idx), .uop_op(uop_op), .uop_dst(uop_dst),
        .uop_srca(uop_srca), .uop_srcb(uop_srcb), .uop_imm(uop_imm), .uop_bytes(uop_bytes),
        .uop_first(uop_first), .uop_last(uop_last), .uop_delayed(uop_delayed),
        .uop_mem(uop_mem), .uop_store(uop_store), .uop_int(uop_int), .uop_micro(uop_micro)
    );

    wire [SNAP_W-1:0] snap = {uop_pc, uop_idx, uop_op, uop_dst, uop_srca, uop_srcb, uop_imm,
                              uop_bytes, uop_first, uop_last, uop_delayed, uop_mem,
                              uop_store, uop_int, uop_micro};

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [REG_W:0] tmp_opnd();
        return {1'b1, REG_W'(TMP_REG)};
    endfunction

    // Compare all micro-op outputs with the values the requirements give for index k.
    task automatic chk_uop(input int k, input logic [PC_W-1:0] pc, input logic [REG_W-1:0] rt1,
                           input logic [REG_W-1:0] rt2, input logic [REG_W-1:0] rn,
                           input logic [IMM_W-1:0] imm, input logic is64);
        logic [1:0]       e_op;
        logic [REG_W:0]   e_dst, e_a, e_b;
        logic [IMM_W-1:0] e_imm;
        logic [3:0]       e_bytes;
        string            rq;
        rq      = (k == 0) ? "R3" : (k == 1) ? "R4" : "R5";
        e_op    = (k == 0) ? 2'b01 : 2'b10;
        e_dst   = (k == 0) ? tmp_opnd() : '0;
        e_a     = (k == 0) ? {1'b0, rn} : tmp_opnd();
        e_b     = (k == 0) ? '0 : (k == 1) ? {1'b0, rt1} : {1'b0, rt2};
        e_imm   = (k == 0) ? imm : (k == 1) ? '0 : (is64 ? IMM_W'(8) : IMM_W'(4));
        e_bytes = (k == 0) ? 4'd0 : (is64 ? 4'd8 : 4'd4);
        chk(out_valid == 1'b1, "R2", "out_valid", 64'(out_valid), 64'd1);
        chk(uop_idx == 2'(k), "R2", "uop_idx", 64'(uop_idx), 64'(k));
        chk(uop_pc == pc, "R2", "uop_pc", 64'(uop_pc), 64'(pc));
        chk({uop_op, uop_dst, uop_srca, uop_srcb} == {e_op, e_dst, e_a, e_b}, rq, "op/regs",
            64'({uop_op, uop_dst, uop_srca, uop_srcb}), 64'({e_op, e_dst, e_a, e_b}));
        chk(uop_imm == e_imm, rq, "uop_imm", 64'(uop_imm), 64'(e_imm));
        chk(uop_bytes == e_bytes, "R5", "uop_bytes", 64'(uop_bytes), 64'(e_bytes));
        chk({uop_first, uop_last, uop_micro} == {k == 0, k == 2, 1'b1}, "R6", "first/last/micro",
            64'({uop_first, uop_last, uop_micro}), 64'({k == 0, k == 2, 1'b1}));
        chk(uop_delayed == (k != 2), "R7", "uop_delayed", 64'(uop_delayed), 64'(k != 2));
        chk({uop_mem, uop_store, uop_int} == {k != 0, k != 0, k == 0}, "R8", "mem/store/int",
            64'({uop_mem, uop_store, uop_int}), 64'({k != 0, k != 0, k == 0}));
        chk(in_ready == 1'b0, "R9", "in_ready busy", 64'(in_ready), 64'd0);
    endtask

    // Run one instruction through the block; max_stall bounds backpressure, garble drives junk input (R12).
    task automatic run_instr(input logic [PC_W-1:0] pc, input logic [REG_W-1:0] rt1,
                             input logic [REG_W-1:0] rt2, input logic [REG_W-1:0] rn,
                             input logic [IMM_W-1:0] imm, input logic is64,
                             input int max_stall, input bit garble);
        logic [SNAP_W-1:0] held;
        chk(in_ready == 1'b1, "R9", "in_ready idle", 64'(in_ready), 64'd1);
        in_valid = 1'b1; in_pc = pc; in_rt1 = rt1; in_rt2 = rt2;
        in_rn = rn; in_imm = imm; in_is64 = is64;
        @(posedge clk); @(negedge clk);
        in_valid = garble;
        for (int k = 0; k < 3; k++) begin
            int stalls = (max_stall > 0) ? $urandom_range(0, max_stall) : 0;
            for (int s = 0; s < stalls; s++) begin
                if (garble) begin
                    in_pc = PC_W'({$urandom, $urandom}); in_imm = IMM_W'($urandom);
                    in_rt1 = REG_W'($urandom); in_rt2 = REG_W'($urandom); in_rn = REG_W'($urandom);
                    in_is64 = 1'($urandom);
                end
                out_ready = 1'b0;
                chk_uop(k, pc, rt1, rt2, rn, imm, is64);
                held = snap;
                @(posedge clk); @(negedge clk);
                chk(snap == held, "R10", "stall hold", 64'(snap), 64'(held));
            end
            out_ready = 1'b1;
            chk_uop(k, pc, rt1, rt2, rn, imm, is64);
            if (k == 2) in_valid = 1'b0;
            @(posedge clk); @(negedge clk);
            out_ready = 1'b0;
        end
        chk(out_valid == 1'b0, "R9", "out_valid after last", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R9", "in_ready after last", 64'(in_ready), 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid reset", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R1", "in_ready reset", 64'(in_ready), 64'd1);
        // R11: zero offset, 64-bit, no stall.
        run_instr(48'h1234_5678_9ABC, 5'd1, 5'd2, 5'd0, 9'd0, 1'b1, 0, 1'b0);
        // Negative extreme offset, 32-bit (R3, R5).
        run_instr(48'h0000_0040_0078, 5'd30, 5'd31, 5'd29, 9'h100, 1'b0, 0, 1'b0);
        // Positive extreme offset with stalls (R10).
        run_instr(48'hFFFF_FFFF_FFFC, 5'd7, 5'd8, 5'd9, 9'd255, 1'b1, 2, 1'b0);
        // Same data register twice with junk input while busy (R12).
        run_instr(48'h0000_0000_0004, 5'd5, 5'd5, 5'd31, 9'h1F0, 1'b0, 2, 1'b1);
        for (int i = 0; i < 40; i++) begin
            run_instr(PC_W'({$urandom, $urandom}), REG_W'($urandom), REG_W'($urandom),
                      REG_W'($urandom), IMM_W'($urandom), 1'($urandom), 2, 1'($urandom));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule